// File: doc/BRIEF.md
# Two-Cluster Thread-Aware Memory Request Arbiter

This block chooses which pending memory request goes next to the DRAM command logic of one memory controller that several hardware threads share. Requests come in one per cycle on an enqueue port. Each request carries a thread number, a bank, a row and an age stamp, and waits in a small buffer of fixed depth. The command side takes one request per cycle through a valid/ready handshake.

The arbiter counts each thread's enqueued requests over a quantum whose length software can set. At every quantum boundary it splits the threads into two groups. The light group holds the least memory-intensive threads. Within that group, lower intensity gives higher priority, and any light thread outranks any heavy one. The heavy group is ordered by a rotating pointer that advances at a second programmable interval. A thread marked as vulnerable to interference keeps the pointer for one extra interval. Among requests of equal thread priority, a hit on the bank's open row wins, and after that the oldest request wins. The cluster threshold moves the split point, which trades throughput against fairness.

Top module: `tcmSched`

## Requirements
- R1: From reset until the first quantum boundary, every thread has the same priority, and the buffer is empty with `issueValid` low.
- R2: A request is accepted on a cycle with `enqValid` and `enqReady` both high. `enqReady` is low exactly when all DEPTH buffer slots are occupied, and an enqueue attempted while full is dropped.
- R3: `issueValid` is high whenever at least one request is pending. A request leaves the buffer only on a cycle where `issueValid` and `issueReady` are both high.
- R4: A quantum boundary falls on the cycle in which the quantum cycle count plus one reaches `cfgQuantumLen`, so a length of 0 behaves as 1. Each thread's intensity is the number of its requests accepted in the quantum. A request accepted in the boundary cycle counts toward the next quantum.
- R5: At a boundary, threads are sorted by ascending intensity, with ties going to the lower thread number. A thread joins the light group when 16 × (its own intensity plus that of every thread before it in the sort) ≤ `cfgThresh` × (total intensity). All other threads are heavy. The new grouping takes effect from the next cycle.
- R6: A pending request of any light thread is issued before any request of a heavy thread.
- R7: Among light threads, the one earlier in the R5 sort order has higher priority.
- R8: A rotation pointer starts at thread 0 and steps by one (modulo the thread count) on the cycle in which the shuffle cycle count plus one reaches `cfgShuffleLen`. Heavy threads are ranked by (thread − pointer) mod thread count, and the smallest distance ranks highest.
- R9: At a shuffle step, if `cfgVulnerable` bit p is set for the thread p at the pointer and that thread has not already been held, the pointer stays put for one more interval and then moves on at the following step.
- R10: Among pending requests whose threads have equal priority, a request whose row equals the last row issued to its bank wins first; no bank has an open row after reset. After that, the smaller `enqAge` value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enqValid | input | 1 | Enqueue request present |
| enqReady | output | 1 | Buffer has a free slot |
| enqThread | input | $clog2(THREADS) | Requesting thread number |
| enqBank | input | BANK_W | Target bank |
| enqRow | input | ROW_W | Target row |
| enqAge | input | AGE_W | Age stamp, smaller is older |
| issueValid | output | 1 | A request is offered to the command logic |
| issueReady | input | 1 | Command logic takes the offered request |
| issueThread | output | $clog2(THREADS) | Thread of the offered request |
| issueBank | output | BANK_W | Bank of the offered request |
| issueRow | output | ROW_W | Row of the offered request |
| cfgThresh | input | THR_W | Light-group share in sixteenths of total intensity |
| cfgQuantumLen | input | CNT_W | Quantum length in cycles |
| cfgShuffleLen | input | CNT_W | Heavy-rotation interval in cycles |
| cfgVulnerable | input | THREADS | Per-thread flag for the extra pointer dwell |

## Verification
Random traffic skewed toward one thread is checked cycle by cycle against a bench-side model, at thresholds of 0, 4, 8, 12 and 16 sixteenths. At 0 every thread that enqueued something goes heavy; at 16 every thread stays light. A design with an off-by-one in the prefix-sum test, or one that misses equal-intensity ties, would issue a different thread at the next boundary. Very short shuffle intervals, including a quantum of one cycle, catch a pointer that ignores the vulnerable dwell or that holds the same thread twice in a row. Directed cases fill the buffer and attempt a ninth request, which must not show up in the drain. They also set an open-row hit against an older miss, where reversing the two tiebreaks would issue the wrong row. Finally, an uneven enqueue mix must come out in light-first order after the boundary.

// File: rtl/tcmPkg.sv
package tcmPkg;

  // Cluster threshold is expressed in sixteenths of the total intensity.
  localparam int unsigned THRESH_SCALE = 16;

  // Handshake strobes issued by the control side to the request store.
  typedef struct packed {
    logic enqGo;
    logic issueGo;
  } tcmStrobes_t;

endpackage

// File: rtl/tcmCtrl.sv
module tcmCtrl
  import tcmPkg::*;
#(
  parameter int unsigned THREADS = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned THR_W   = 5,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned PRIO_W = $clog2(2 * THREADS),
  localparam int unsigned SUM_W  = CNT_W + TID_W,
  localparam int unsigned PROD_W = SUM_W + THR_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enqValid,
  input  logic [TID_W-1:0]          enqThread,
  input  logic                      enqReady,
  input  logic                      issueValid,
  input  logic                      issueReady,
  input  logic [THR_W-1:0]          cfgThresh,
  input  logic [CNT_W-1:0]          cfgQuantumLen,
  input  logic [CNT_W-1:0]          cfgShuffleLen,
  input  logic [THREADS-1:0]        cfgVulnerable,
  output tcmStrobes_t               strobes,
  output logic [THREADS*PRIO_W-1:0] threadPrio
);

  logic [CNT_W-1:0]              quantumCnt;
  logic [CNT_W-1:0]              shuffleCnt;
  logic [THREADS-1:0][CNT_W-1:0] intensity;
  logic [THREADS-1:0]            heavyMask;
  logic [THREADS-1:0][TID_W-1:0] lightPos;
  logic [THREADS-1:0]            nextHeavy;
  logic [THREADS-1:0][TID_W-1:0] nextPos;
  logic [TID_W-1:0]              rotPtr;
  logic                          dwelt;
  logic                          ranked;
  logic                          quantumEnd;
  logic                          shuffleTick;
  logic                          enqGo;
  logic [SUM_W-1:0]              totalCnt;

  assign enqGo           = enqValid && enqReady;
  assign strobes.enqGo   = enqGo;
  assign strobes.issueGo = issueValid && issueReady;

  assign quantumEnd  = ({1'b0, quantumCnt} + (CNT_W+1)'(1)) >= {1'b0, cfgQuantumLen};
  assign shuffleTick = ({1'b0, shuffleCnt} + (CNT_W+1)'(1)) >= {1'b0, cfgShuffleLen};

  // Sort position and prefix-sum cluster test for every thread.
  always_comb begin
    logic [SUM_W-1:0] cum;
    logic [TID_W-1:0] pos;
    totalCnt = '0;
    for (int i = 0; i < THREADS; i++) totalCnt = totalCnt + SUM_W'(intensity[i]);
    for (int i = 0; i < THREADS; i++) begin
      cum = '0;
      pos = '0;
      for (int j = 0; j < THREADS; j++) begin
        if ((intensity[j] < intensity[i]) || ((intensity[j] == intensity[i]) && (j <= i))) begin
          cum = cum + SUM_W'(intensity[j]);
          if (j != i) pos = pos + TID_W'(1);
        end
      end
      nextPos[i]   = pos;
      nextHeavy[i] = (PROD_W'(cum) * PROD_W'(THRESH_SCALE)) > (PROD_W'(totalCnt) * PROD_W'(cfgThresh));
    end
  end

  // Quantum timer, intensity counters and cluster registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quantumCnt <= '0;
      intensity  <= '0;
      heavyMask  <= '0;
      lightPos   <= '0;
      ranked     <= 1'b0;
    end else if (quantumEnd) begin
      quantumCnt <= '0;
      heavyMask  <= nextHeavy;
      lightPos   <= nextPos;
      ranked     <= 1'b1;
      for (int t = 0; t < THREADS; t++)
        intensity[t] <= (enqGo && (enqThread == TID_W'(t))) ? CNT_W'(1) : '0;
    end else begin
      quantumCnt <= quantumCnt + CNT_W'(1);
      for (int t = 0; t < THREADS; t++)
        if (enqGo && (enqThread == TID_W'(t)) && (intensity[t] != '1))
          intensity[t] <= intensity[t] + CNT_W'(1);
    end
  end

  // Heavy-cluster rotation with a one-interval hold for vulnerable threads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shuffleCnt <= '0;
      rotPtr     <= '0;
      dwelt      <= 1'b0;
    end else if (shuffleTick) begin
      shuffleCnt <= '0;
      if (cfgVulnerable[rotPtr] && !dwelt) begin
        dwelt <= 1'b1;
      end else begin
        dwelt  <= 1'b0;
        rotPtr <= (rotPtr == TID_W'(THREADS - 1)) ? '0 : rotPtr + TID_W'(1);
      end
    end else begin
      shuffleCnt <= shuffleCnt + CNT_W'(1);
    end
  end

  // Priority code per thread: light threads above THREADS-1, heavy below.
  always_comb begin
    int distI;
    threadPrio = '0;
    for (int i = 0; i < THREADS; i++) begin
      distI = (i - int'(rotPtr) + int'(THREADS)) % int'(THREADS);
      if (!ranked)
        threadPrio[i*PRIO_W +: PRIO_W] = '0;
      else if (!heavyMask[i])
        threadPrio[i*PRIO_W +: PRIO_W] = PRIO_W'(2 * THREADS - 1) - PRIO_W'(lightPos[i]);
      else
        threadPrio[i*PRIO_W +: PRIO_W] = PRIO_W'(int'(THREADS) - 1 - distI);
    end
  end

endmodule

// File: rtl/tcmQueue.sv
module tcmQueue
  import tcmPkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned THREADS = 4,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned AGE_W   = 16,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned PRIO_W = $clog2(2 * THREADS),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned BANKS  = 1 << BANK_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tcmStrobes_t               strobes,
  input  logic [THREADS*PRIO_W-1:0] threadPrio,
  input  logic [TID_W-1:0]          enqThread,
  input  logic [BANK_W-1:0]         enqBank,
  input  logic [ROW_W-1:0]          enqRow,
  input  logic [AGE_W-1:0]          enqAge,
  output logic                      enqReady,
  output logic                      issueValid,
  output logic [TID_W-1:0]          issueThread,
  output logic [BANK_W-1:0]         issueBank,
  output logic [ROW_W-1:0]          issueRow,
  output logic [DEPTH-1:0]          pendMask
);

  typedef struct packed {
    logic [TID_W-1:0]  thread;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [AGE_W-1:0]  age;
  } slot_t;

  slot_t              slots [DEPTH];
  logic [DEPTH-1:0]   slotValid;
  logic [ROW_W-1:0]   openRow [BANKS];
  logic [BANKS-1:0]   openValid;
  logic [IDX_W-1:0]   freeIdx;
  logic               freeFound;
  logic [IDX_W-1:0]   bestIdx;
  logic               bestFound;

  assign pendMask = slotValid;
  assign enqReady = freeFound;

  // Lowest free slot.
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!slotValid[k] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(k);
      end
    end
  end

  // Winner: thread priority, then open-row hit, then smallest age stamp.
  always_comb begin
    logic [PRIO_W-1:0] bestPrio;
    logic              bestHit;
    logic [AGE_W-1:0]  bestAge;
    logic [PRIO_W-1:0] kPrio;
    logic              kHit;
    logic              better;
    bestFound = 1'b0;
    bestIdx   = '0;
    bestPrio  = '0;
    bestHit   = 1'b0;
    bestAge   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      kPrio  = threadPrio[int'(slots[k].thread)*PRIO_W +: PRIO_W];
      kHit   = openValid[slots[k].bank] && (openRow[slots[k].bank] == slots[k].row);
      better = !bestFound || (kPrio > bestPrio) ||
               ((kPrio == bestPrio) && ((kHit && !bestHit) ||
                                        ((kHit == bestHit) && (slots[k].age < bestAge))));
      if (slotValid[k] && better) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(k);
        bestPrio  = kPrio;
        bestHit   = kHit;
        bestAge   = slots[k].age;
      end
    end
  end

  assign issueValid  = bestFound;
  assign issueThread = slots[bestIdx].thread;
  assign issueBank   = slots[bestIdx].bank;
  assign issueRow    = slots[bestIdx].row;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      openValid <= '0;
    end else begin
      if (strobes.enqGo) slotValid[freeIdx] <= 1'b1;
      if (strobes.issueGo) begin
        slotValid[bestIdx]          <= 1'b0;
        openValid[slots[bestIdx].bank] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.enqGo) slots[freeIdx] <= '{thread: enqThread, bank: enqBank, row: enqRow, age: enqAge};
    if (strobes.issueGo) openRow[slots[bestIdx].bank] <= slots[bestIdx].row;
  end

endmodule

// File: rtl/tcmSched.sv
module tcmSched
  import tcmPkg::*;
#(
  parameter int unsigned THREADS = 4,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned AGE_W   = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned THR_W   = 5,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned PRIO_W = $clog2(2 * THREADS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enqValid,
  output logic               enqReady,
  input  logic [TID_W-1:0]   enqThread,
  input  logic [BANK_W-1:0]  enqBank,
  input  logic [ROW_W-1:0]   enqRow,
  input  logic [AGE_W-1:0]   enqAge,
  output logic               issueValid,
  input  logic               issueReady,
  output logic [TID_W-1:0]   issueThread,
  output logic [BANK_W-1:0]  issueBank,
  output logic [ROW_W-1:0]   issueRow,
  input  logic [THR_W-1:0]   cfgThresh,
  input  logic [CNT_W-1:0]   cfgQuantumLen,
  input  logic [CNT_W-1:0]   cfgShuffleLen,
  input  logic [THREADS-1:0] cfgVulnerable
);

  tcmStrobes_t               strobes;
  logic [THREADS*PRIO_W-1:0] threadPrio;
  logic [DEPTH-1:0]          pendMask;

  tcmCtrl #(.THREADS(THREADS), .CNT_W(CNT_W), .THR_W(THR_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqThread(enqThread), .enqReady(enqReady),
    .issueValid(issueValid), .issueReady(issueReady),
    .cfgThresh(cfgThresh), .cfgQuantumLen(cfgQuantumLen),
    .cfgShuffleLen(cfgShuffleLen), .cfgVulnerable(cfgVulnerable),
    .strobes(strobes), .threadPrio(threadPrio)
  );

  tcmQueue #(.DEPTH(DEPTH), .THREADS(THREADS), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)) store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .threadPrio(threadPrio),
    .enqThread(enqThread), .enqBank(enqBank), .enqRow(enqRow), .enqAge(enqAge),
    .enqReady(enqReady), .issueValid(issueValid), .issueThread(issueThread),
    .issueBank(issueBank), .issueRow(issueRow), .pendMask(pendMask)
  );

endmodule

// File: rtl/tcmSchedChecker.sv
module tcmSchedChecker #(
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enqValid,
  input logic             enqReady,
  input logic             issueValid,
  input logic             issueReady,
  input logic [DEPTH-1:0] pendMask
);

  logic seenEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  // R1: the first cycle out of reset sees an empty, idle buffer.
  assert_clean_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seenEdge |-> (pendMask == '0) && !issueValid);

  // R2: an accepted enqueue without an issue grows the occupancy by one.
  assert_enq_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && enqReady && !(issueValid && issueReady)) |=>
      ($countones(pendMask) == $past($countones(pendMask)) + 1));

  // R2: with no space and no issue, the buffer is left untouched.
  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!enqReady && !(issueValid && issueReady)) |=> $stable(pendMask));

  // R3: an issue without an enqueue shrinks the occupancy by one.
  assert_issue_drains_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !(enqValid && enqReady)) |=>
      ($countones(pendMask) == $past($countones(pendMask)) - 1));

  // R3: a stalled offer stays offered.
  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady) |=> issueValid);

  // R3: nothing pending means nothing offered.
  assert_empty_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendMask == '0) |-> !issueValid);

endmodule

bind tcmSched tcmSchedChecker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
  .issueValid(issueValid), .issueReady(issueReady), .pendMask(pendMask)
);

// File: tb/tcmSched_test.sv
module tcmSched_test;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 4;
  localparam int DEPTH   = 8;
  localparam int BANKS   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enqValid = 1'b0;
  logic       enqReady;
  logic [1:0] enqThread = '0;
  logic [1:0] enqBank = '0;
  logic [7:0] enqRow = '0;
  logic [15:0] enqAge = '0;
  logic       issueValid;
  logic       issueReady = 1'b0;
  logic [1:0] issueThread;
  logic [1:0] issueBank;
  logic [7:0] issueRow;
  logic [4:0] cfgThresh = 5'd8;
  logic [15:0] cfgQuantumLen = 16'd1000;
  logic [15:0] cfgShuffleLen = 16'd1000;
  logic [3:0] cfgVulnerable = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcmSched uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqThread(enqThread), .enqBank(enqBank), .enqRow(enqRow), .enqAge(enqAge),
    .issueValid(issueValid), .issueReady(issueReady), .issueThread(issueThread),
    .issueBank(issueBank), .issueRow(issueRow), .cfgThresh(cfgThresh),
    .cfgQuantumLen(cfgQuantumLen), .cfgShuffleLen(cfgShuffleLen),
    .cfgVulnerable(cfgVulnerable)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench-side model state
  bit mValid[DEPTH];
  int mThr[DEPTH], mBank[DEPTH], mRow[DEPTH], mAge[DEPTH];
  bit mOpenV[BANKS];
  int mOpenRow[BANKS];
  int mCnt[THREADS], mPos[THREADS];
  bit mHeavy[THREADS];
  bit mRanked, mDwelt;
  int mRot, mQCnt, mSCnt;
  int stamp = 0;
  bit gotFire;
  int gotThread, gotRow;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int k = 0; k < DEPTH; k++) mValid[k] = 0;
    for (int b = 0; b < BANKS; b++) begin mOpenV[b] = 0; mOpenRow[b] = 0; end
    for (int t = 0; t < THREADS; t++) begin mCnt[t] = 0; mPos[t] = 0; mHeavy[t] = 0; end
    mRanked = 0; mDwelt = 0; mRot = 0; mQCnt = 0; mSCnt = 0;
  endfunction

  function automatic int expPrio(int t);
    if (!mRanked) return 0;
    if (!mHeavy[t]) return 2*THREADS - 1 - mPos[t];
    return THREADS - 1 - ((t - mRot + THREADS) % THREADS);
  endfunction

  function automatic int pickIdx();
    int best = -1; int bp = 0; bit bh = 0; int ba = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (mValid[k]) begin
        int p = expPrio(mThr[k]);
        bit h = mOpenV[mBank[k]] && (mOpenRow[mBank[k]] == mRow[k]);
        if (best < 0 || p > bp || (p == bp && ((h && !bh) || (h == bh && mAge[k] < ba)))) begin
          best = k; bp = p; bh = h; ba = mAge[k];
        end
      end
    end
    return best;
  endfunction

  // Sort threads by (intensity, id) and grow the light group while under the share.
  function automatic void classify();
    int order[THREADS];
    int total = 0; int cum = 0;
    for (int t = 0; t < THREADS; t++) begin order[t] = t; total += mCnt[t]; end
    for (int a = 0; a < THREADS; a++)
      for (int b = a + 1; b < THREADS; b++)
        if (mCnt[order[b]] < mCnt[order[a]] ||
            (mCnt[order[b]] == mCnt[order[a]] && order[b] < order[a])) begin
          int tmp = order[a]; order[a] = order[b]; order[b] = tmp;
        end
    for (int k = 0; k < THREADS; k++) begin
      cum += mCnt[order[k]];
      mHeavy[order[k]] = (cum * 16) > (int'(cfgThresh) * total);
      mPos[order[k]] = k;
    end
    mRanked = 1;
  endfunction

  // Compare outputs for the current state, drive inputs, advance the model by one edge.
  task automatic cycleBody(bit ev, int th, int bk, int rw, bit ir);
    int idx = pickIdx();
    int freeSlot = -1;
    bit enqGo, issueGo;
    for (int k = 0; k < DEPTH; k++) if (!mValid[k] && freeSlot < 0) freeSlot = k;
    check(issueValid == (idx >= 0), "R3", "issueValid", int'(issueValid), int'(idx >= 0));
    check(enqReady == (freeSlot >= 0), "R2", "enqReady", int'(enqReady), int'(freeSlot >= 0));
    if (idx >= 0 && issueValid) begin
      check(int'(issueThread) == mThr[idx], "R4 R5 R6 R7 R8 R9 R10", "issueThread", int'(issueThread), mThr[idx]);
      check(int'(issueBank) == mBank[idx], "R10", "issueBank", int'(issueBank), mBank[idx]);
      check(int'(issueRow) == mRow[idx], "R10", "issueRow", int'(issueRow), mRow[idx]);
    end
    gotFire = issueValid && ir;
    gotThread = int'(issueThread);
    gotRow = int'(issueRow);
    enqValid = ev; enqThread = 2'(th); enqBank = 2'(bk); enqRow = 8'(rw);
    enqAge = 16'(stamp); issueReady = ir;
    enqGo = ev && (freeSlot >= 0);
    issueGo = (idx >= 0) && ir;
    if (issueGo) begin
      mValid[idx] = 0; mOpenV[mBank[idx]] = 1; mOpenRow[mBank[idx]] = mRow[idx];
    end
    if (enqGo) begin
      mValid[freeSlot] = 1; mThr[freeSlot] = th; mBank[freeSlot] = bk;
      mRow[freeSlot] = rw; mAge[freeSlot] = stamp; stamp++;
    end
    if (mQCnt + 1 >= int'(cfgQuantumLen)) begin
      classify();
      mQCnt = 0;
      for (int t = 0; t < THREADS; t++) mCnt[t] = 0;
      if (enqGo) mCnt[th] = 1;
    end else begin
      mQCnt++;
      if (enqGo) mCnt[th]++;
    end
    if (mSCnt + 1 >= int'(cfgShuffleLen)) begin
      mSCnt = 0;
      if (cfgVulnerable[mRot] && !mDwelt) mDwelt = 1;
      else begin mRot = (mRot + 1) % THREADS; mDwelt = 0; end
    end else mSCnt++;
  endtask

  task automatic step(bit ev, int th, int bk, int rw, bit ir);
    @(negedge clk);
    cycleBody(ev, th, bk, rw, ir);
  endtask

  task automatic doReset(int thr, int qlen, int slen, int vuln);
    @(negedge clk);
    rstN = 0; enqValid = 0; issueReady = 0;
    cfgThresh = 5'(thr); cfgQuantumLen = 16'(qlen);
    cfgShuffleLen = 16'(slen); cfgVulnerable = 4'(vuln);
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    check(issueValid == 1'b0, "R1", "issueValid after reset", int'(issueValid), 0);
    check(enqReady == 1'b1, "R2", "enqReady after reset", int'(enqReady), 1);
    cycleBody(0, 0, 0, 0, 0);
  endtask

  task automatic randomPhase(int thr, int qlen, int slen, int vuln, int cycles);
    doReset(thr, qlen, slen, vuln);
    for (int c = 0; c < cycles; c++) begin
      int r = $urandom % 16;
      int th = (r < 8) ? 0 : (r < 12) ? 1 : (r < 14) ? 2 : 3;
      step(($urandom % 100) < 55, th, $urandom % 4, $urandom % 4, ($urandom % 100) < 45);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_7c41));

    // R1/R10: equal rank before the first boundary; row hit, then age
    doReset(8, 1000, 1000, 0);
    step(1, 1, 0, 5, 0);
    step(0, 0, 0, 0, 1);
    step(1, 2, 0, 7, 0);
    step(1, 3, 0, 5, 0);
    step(0, 0, 0, 0, 1);
    check(gotFire && gotRow == 5, "R10", "open-row hit beats older miss (row)", gotRow, 5);
    check(gotThread == 3, "R1", "equal rank lets the hit win (thread)", gotThread, 3);
    step(0, 0, 0, 0, 1);
    step(1, 1, 1, 2, 0);
    step(1, 2, 1, 3, 0);
    step(0, 0, 0, 0, 1);
    check(gotFire && gotThread == 1, "R10", "oldest among misses", gotThread, 1);
    step(0, 0, 0, 0, 1);

    // R2: fill, attempt one more, drain and count
    doReset(8, 1000, 1000, 0);
    for (int k = 0; k < DEPTH; k++) step(1, k % 4, k % 4, 10 + k, 0);
    step(1, 0, 0, 99, 0);
    check(enqReady == 1'b0, "R2", "enqReady when full", int'(enqReady), 0);
    begin
      int n = 0;
      for (int k = 0; k < 12; k++) begin
        step(0, 0, 0, 0, 1);
        if (gotFire) n++;
        if (gotFire) check(gotRow != 99, "R2", "dropped request row absent", gotRow, 0);
      end
      check(n == DEPTH, "R2", "requests drained", n, DEPTH);
    end

    // R6/R7: uneven mix, then drain after the first boundary
    doReset(8, 20, 1000, 0);
    for (int k = 0; k < 4; k++) step(1, 0, 0, 1, 0);
    step(1, 1, 1, 1, 0);
    step(1, 2, 2, 1, 0);
    step(1, 2, 2, 2, 0);
    for (int k = 0; k < 18; k++) step(0, 0, 0, 0, 0);
    begin
      int seq[7];
      for (int k = 0; k < 7; k++) begin step(0, 0, 0, 0, 1); seq[k] = gotThread; end
      check(seq[0] == 1, "R7", "lightest thread first", seq[0], 1);
      check(seq[1] == 2 && seq[2] == 2, "R7", "second light thread next", seq[1], 2);
      for (int k = 3; k < 7; k++) check(seq[k] == 0, "R6", "heavy thread last", seq[k], 0);
    end

    // Random phases across thresholds, quanta and shuffle settings (R4 R5 R8 R9)
    randomPhase(8, 64, 9, 4'b0101, 3000);
    randomPhase(4, 50, 5, 4'b0010, 3000);
    randomPhase(0, 30, 7, 4'b1111, 2000);
    randomPhase(16, 100, 11, 4'b0000, 2000);
    randomPhase(12, 1, 1, 4'b0101, 1000);
    randomPhase(6, 0, 3, 4'b1001, 1000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule